// File: doc/BRIEF.md
# Two-Level Round-Robin Block Lane Spreader

This block takes a stream of 64-bit data blocks on a valid/ready input and spreads them over N = P x Q parallel lane outputs. The spreading is done in two stages. An outer selector hands consecutive units of Q blocks to P independent group distributors in turn. Each group distributor buffers its unit and then passes the blocks, one per clock, to its Q local lanes in ascending order. No single stage ever steps through all N lanes. A group can fill while the previous group is still handing out its unit.

Lane j of the output bus is the pair `lane_valid[j]` and `lane_data[64*j+63 : 64*j]`. The global lane index is `group * Q + local_lane`. A block on a lane is marked by a one-cycle valid pulse, and the lane data register keeps that block until the lane's next pulse. With P = 1 and Q = N the block acts as a flat single-stage round robin over N lanes. A synchronous reset sets both pointers back to zero and drops any unit that was only partly filled.

Top module: `rr2_lane_spreader`

## Requirements
- R1: The block has N = GROUPS x LANES_PER_GROUP lanes. Lane j is `lane_valid[j]` with `lane_data[BLK_W*j +: BLK_W]`, and global lane j is local lane (j mod LANES_PER_GROUP) of group (j div LANES_PER_GROUP).
- R2: Counting accepted blocks from 0 after reset, block m appears exactly once, unchanged, on global lane m mod N. Output pulses occur in the order the blocks were accepted.
- R3: The outer selector sends accepted blocks in units of LANES_PER_GROUP consecutive blocks, with unit k going to group k mod GROUPS. Its group pointer moves only when the last block of a unit is accepted. A unit that is only partly filled produces no output.
- R4: Once its unit is complete, a group emits the blocks on local lanes 0, 1, ..., Q-1 on consecutive cycles. Each valid pulse lasts one cycle, and at most one lane of the whole block is valid in any cycle.
- R5: `in_ready` is low exactly while the group being filled is still emitting its previous unit. A block offered while `in_ready` is low is not taken and does not move any pointer. With GROUPS >= 2, a back-to-back input stream never sees `in_ready` low.
- R6: With GROUPS = 1 and LANES_PER_GROUP = N, block m goes to lane m mod N. After each full unit, the input is held off for N cycles while the unit is emitted.
- R7: A synchronous, active-high `rst` clears the outer and inner pointers and all lane valids and drops any partial unit. After reset `in_ready` is high and the next accepted block goes to lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input block valid |
| in_data | input | BLK_W | Input 64-bit block |
| in_ready | output | 1 | Input can accept a block this cycle |
| lane_valid | output | N | One-cycle strobe per lane: a new block is on that lane |
| lane_data | output | N*BLK_W | Per-lane block registers, lane j at bits BLK_W*j upward |

## Verification
The bench builds two copies of the block, both with eight lanes. One uses two groups of four. It shows that a continuous stream never stalls, that a group emits its four lanes on consecutive cycles, and that a partial unit is dropped by reset. The other uses one group of eight, which is the flat case. It makes the emit-time backpressure visible and shows that the lane mapping matches the two-stage instance for the same block numbers.

// File: rtl/rr2_pkg.sv
package rr2_pkg;

  typedef enum logic {
    GRP_FILL  = 1'b0,
    GRP_DRAIN = 1'b1
  } grp_state_t;

  // global lane number of a local lane within a group
  function automatic int unsigned flat_lane(input int unsigned grp,
                                            input int unsigned loc,
                                            input int unsigned per_grp);
    return grp * per_grp + loc;
  endfunction

  // next pointer value for a counter that wraps at lim
  function automatic int unsigned wrap_inc(input int unsigned v,
                                           input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // index width that stays at least one bit
  function automatic int unsigned idx_w(input int unsigned cnt);
    return (cnt > 1) ? $clog2(cnt) : 1;
  endfunction

endpackage

// File: rtl/rr2_group_sel.sv
module rr2_group_sel
  import rr2_pkg::*;
#(
  parameter int unsigned P  = 2,
  parameter int unsigned Q  = 4,
  localparam int unsigned GW = idx_w(P),
  localparam int unsigned SW = idx_w(Q)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [P-1:0]  sub_ready,
  output logic          in_ready,
  output logic          accept,
  output logic          unit_done,
  output logic [P-1:0]  wr_en,
  output logic [SW-1:0] wr_slot,
  output logic [GW-1:0] grp_ptr
);

  logic [GW-1:0] grp_q;
  logic [SW-1:0] slot_q;

  always_comb begin
    in_ready  = sub_ready[grp_q];
    accept    = in_valid && in_ready;
    unit_done = accept && (slot_q == SW'(Q - 1));
    wr_en     = '0;
    if (accept) wr_en[grp_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q  <= '0;
      slot_q <= '0;
    end else if (accept) begin
      slot_q <= SW'(wrap_inc(int'(slot_q), Q));
      if (unit_done) grp_q <= GW'(wrap_inc(int'(grp_q), P));
    end
  end

  assign wr_slot = slot_q;
  assign grp_ptr = grp_q;

endmodule

// File: rtl/rr2_sub_lane.sv
module rr2_sub_lane
  import rr2_pkg::*;
#(
  parameter int unsigned Q     = 4,
  parameter int unsigned BLK_W = 64,
  localparam int unsigned SW   = idx_w(Q)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SW-1:0]      wr_slot,
  input  logic [BLK_W-1:0]   wr_data,
  output logic               ready,
  output logic               drain_last,
  output logic [Q-1:0]       lane_valid,
  output logic [Q*BLK_W-1:0] lane_data
);

  grp_state_t       st_q;
  logic [SW-1:0]    rd_q;
  logic [BLK_W-1:0] slot_mem [Q];
  logic             drain_fire;

  assign ready      = (st_q == GRP_FILL);
  assign drain_fire = (st_q == GRP_DRAIN);
  assign drain_last = drain_fire && (rd_q == SW'(Q - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= GRP_FILL;
      rd_q       <= '0;
      lane_valid <= '0;
    end else begin
      lane_valid <= '0;
      if (drain_fire) begin
        lane_valid[rd_q] <= 1'b1;
        rd_q <= SW'(wrap_inc(int'(rd_q), Q));
        if (drain_last) st_q <= GRP_FILL;
      end else if (wr_en && wr_slot == SW'(Q - 1)) begin
        st_q <= GRP_DRAIN;
        rd_q <= '0;
      end
    end
  end

  for (genvar l = 0; l < Q; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && ready && wr_slot == SW'(l)) slot_mem[l] <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (drain_fire && rd_q == SW'(l)) lane_data[l*BLK_W +: BLK_W] <= slot_mem[l];
    end
  end

endmodule

// File: rtl/rr2_lane_spreader.sv
module rr2_lane_spreader
  import rr2_pkg::*;
#(
  parameter int unsigned GROUPS          = 2,
  parameter int unsigned LANES_PER_GROUP = 4,
  parameter int unsigned BLK_W           = 64,
  localparam int unsigned N  = GROUPS * LANES_PER_GROUP,
  localparam int unsigned GW = idx_w(GROUPS),
  localparam int unsigned SW = idx_w(LANES_PER_GROUP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [BLK_W-1:0]   in_data,
  output logic               in_ready,
  output logic [N-1:0]       lane_valid,
  output logic [N*BLK_W-1:0] lane_data
);

  logic [GROUPS-1:0] sub_ready;
  logic [GROUPS-1:0] wr_en;
  logic [GROUPS-1:0] drain_last;
  logic [SW-1:0]     wr_slot;
  logic [GW-1:0]     grp_ptr;
  logic              accept;
  logic              unit_done;

  rr2_group_sel #(.P(GROUPS), .Q(LANES_PER_GROUP)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sub_ready (sub_ready),
    .in_ready  (in_ready),
    .accept    (accept),
    .unit_done (unit_done),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .grp_ptr   (grp_ptr)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int unsigned BASE = flat_lane(g, 0, LANES_PER_GROUP);
    rr2_sub_lane #(.Q(LANES_PER_GROUP), .BLK_W(BLK_W)) u_sub (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en[g]),
      .wr_slot    (wr_slot),
      .wr_data    (in_data),
      .ready      (sub_ready[g]),
      .drain_last (drain_last[g]),
      .lane_valid (lane_valid[BASE +: LANES_PER_GROUP]),
      .lane_data  (lane_data[BASE*BLK_W +: LANES_PER_GROUP*BLK_W])
    );
  end

endmodule

// File: rtl/rr2_lane_spreader_chk.sv
module rr2_lane_spreader_chk #(
  parameter int unsigned P = 2,
  parameter int unsigned Q = 4,
  localparam int unsigned N  = P * Q,
  localparam int unsigned GW = (P > 1) ? $clog2(P) : 1,
  localparam int unsigned SW = (Q > 1) ? $clog2(Q) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          unit_done,
  input logic [N-1:0]  lane_valid,
  input logic [GW-1:0] grp_ptr,
  input logic [SW-1:0] wr_slot
);

  // R4
  lanes_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_valid));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !unit_done |=> $stable(grp_ptr));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    unit_done |=> grp_ptr == (($past(grp_ptr) == GW'(P - 1)) ? '0 : $past(grp_ptr) + 1'b1));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> ($stable(wr_slot) && $stable(grp_ptr)));

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grp_ptr == '0 && wr_slot == '0 && lane_valid == '0 && in_ready));

endmodule

bind rr2_lane_spreader rr2_lane_spreader_chk #(.P(GROUPS), .Q(LANES_PER_GROUP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .unit_done  (unit_done),
  .lane_valid (lane_valid),
  .grp_ptr    (grp_ptr),
  .wr_slot    (wr_slot)
);

// File: tb/rr2_lane_spreader_test.sv
module rr2_lane_spreader_test;

  localparam int NL = 8;
  localparam int W  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          inv [2];
  logic [W-1:0]  ind [2];
  logic          rdy [2];
  logic [NL-1:0] lv  [2];
  logic [NL*W-1:0] ld [2];

  int checks = 0;
  int errors = 0;
  int sent  [2];
  int recv  [2];
  int stall [2];
  int cyc = 0;
  int last_lane [2];
  int last_cyc  [2];
  bit mon_on = 1'b0;

  rr2_lane_spreader #(.GROUPS(2), .LANES_PER_GROUP(4), .BLK_W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(inv[0]), .in_data(ind[0]),
    .in_ready(rdy[0]), .lane_valid(lv[0]), .lane_data(ld[0]));

  rr2_lane_spreader #(.GROUPS(1), .LANES_PER_GROUP(8), .BLK_W(W)) uut_flat (
    .clk(clk), .rst(rst), .in_valid(inv[1]), .in_data(ind[1]),
    .in_ready(rdy[1]), .lane_valid(lv[1]), .lane_data(ld[1]));

  function automatic logic [W-1:0] pat(input int d, input int m);
    return {8'hA0 + 8'(d), 24'(m), ~32'(m * 7)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // output monitor, sampled half a cycle after the edge
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      for (int d = 0; d < 2; d++) begin
        chk($countones(lv[d]) <= 1, "R4", "lanes valid in one cycle", $countones(lv[d]), 1);
        for (int j = 0; j < NL; j++) begin
          if (lv[d][j]) begin
            // R2: block m on lane m mod N with its own data
            chk(j == recv[d] % NL, (d == 0) ? "R2" : "R6", "lane of block", j, recv[d] % NL);
            chk(ld[d][j*W +: W] == pat(d, recv[d]), "R2", "data of block",
                longint'(ld[d][j*W +: W]), longint'(pat(d, recv[d])));
            // R4: inside a group of four, lanes follow on consecutive cycles
            if (d == 0 && (j % 4) != 0)
              chk(last_lane[0] == j - 1 && last_cyc[0] == cyc - 1, "R4",
                  "previous lane in group", last_lane[0], j - 1);
            last_lane[d] = j;
            last_cyc[d]  = cyc;
            recv[d]++;
          end
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    inv[0] = 1'b0;
    inv[1] = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int d = 0; d < 2; d++) begin
      sent[d] = 0; recv[d] = 0; stall[d] = 0; last_lane[d] = -1; last_cyc[d] = -10;
    end
  endtask

  task automatic send(input int d, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      bit ok;
      @(negedge clk);
      inv[d] = 1'b1;
      ind[d] = pat(d, sent[d]);
      forever begin
        ok = rdy[d];
        if (!ok) stall[d]++;
        @(posedge clk);
        if (ok) break;
        @(negedge clk);
      end
      sent[d]++;
      if (gap > 0) begin
        @(negedge clk);
        inv[d] = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    inv[d] = 1'b0;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    chk(rdy[0] == 1'b1, "R7", "two-stage ready after reset", rdy[0], 1);
    chk(rdy[1] == 1'b1, "R7", "flat ready after reset", rdy[1], 1);
    chk(lv[0] == '0 && lv[1] == '0, "R7", "lane valids after reset", lv[0] | lv[1], 0);
  endtask

  task automatic t_stream();
    do_reset();
    send(0, 24, 0);
    settle();
    chk(stall[0] == 0, "R5", "stalls on back-to-back two-group stream", stall[0], 0);
    chk(recv[0] == 24, "R3", "blocks emitted", recv[0], 24);
  endtask

  task automatic t_gaps();
    do_reset();
    send(0, 16, 3);
    settle();
    chk(recv[0] == 16, "R2", "blocks emitted with input gaps", recv[0], 16);
  endtask

  task automatic t_flat();
    do_reset();
    send(1, 16, 0);
    chk(rdy[1] == 1'b0, "R5", "flat ready while unit drains", rdy[1], 0);
    settle();
    chk(stall[1] == 8, "R6", "flat stall cycles for two units", stall[1], 8);
    chk(recv[1] == 16, "R6", "flat blocks emitted", recv[1], 16);
    chk(rdy[1] == 1'b1, "R5", "flat ready after drain", rdy[1], 1);
  endtask

  task automatic t_partial_reset();
    do_reset();
    send(0, 3, 0);
    settle();
    chk(recv[0] == 0, "R3", "outputs from partial unit", recv[0], 0);
    do_reset();
    send(0, 8, 1);
    settle();
    chk(recv[0] == 8, "R7", "blocks after reset restart at lane 0", recv[0], 8);
    chk(last_lane[0] == 7, "R1", "last lane of two full units", last_lane[0], 7);
  endtask

  initial begin
    inv[0] = 1'b0; inv[1] = 1'b0;
    ind[0] = '0;   ind[1] = '0;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;
    t_reset_state();
    t_stream();
    t_gaps();
    t_flat();
    t_partial_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule